// File: doc/BRIEF.md
# Micro-step phase current sequencer

This block turns a stream of step strobes into signed current targets for the two windings of a bipolar stepper motor. It keeps an electrical angle as a position index. Each strobe moves that angle forward or backward by an amount set by the selected step resolution. The block then reads a quarter-wave cosine table, in percent, and produces one target for each phase. Phase B lags phase A by a quarter of an electrical cycle. Both targets are scaled by a torque code.

A separate active-low home input parks the sequencer at the home position of the selected resolution. A flag reports when the position sits at that home. A drive-enable input blanks the targets without freezing the angle, so the angle keeps advancing and output resumes at the correct place. All inputs are synchronous to the system clock, and the step input is a one-cycle strobe. The analog current loop, the chopper timing and the bridge drive are built elsewhere.

Top module: `microstep_seq`

## Requirements
- R1: While `rst` is high, `cur_a` and `cur_b` read 0, and `drive_on` and `at_home` read 0.
- R2: While `home_n` is low, the position is parked at the home of the resolution on `mode`, step strobes are ignored, and `at_home` is 1. With torque 100% and drive enabled, the full-step home gives A=+100 and B=-100. Every other resolution gives A=+100 and B=0 at home.
- R3: Resolution code `mode`=00 is full step. Forward steps from home give (A,B) = (+100,+100), then (-100,+100), then (-100,-100), then (+100,-100).
- R4: Code 01 is half step. Phase A follows the cosine magnitudes 100, 71, 0 in eighth-of-a-cycle steps, and B = A taken a quarter cycle earlier.
- R5: Code 10 is quarter step. It uses the magnitudes 100, 92, 71, 38, 0 per quarter wave.
- R6: Code 11 is eighth step. It uses the magnitudes 100, 98, 92, 83, 71, 56, 38, 20, 0 per quarter wave, so 32 steps make one electrical cycle.
- R7: `dir_rev`=0 steps forward and `dir_rev`=1 steps backward through the same sequence.
- R8: `at_home` drops after any step away from home and rises again whenever the position returns to home.
- R9: With `drive_en` low, both targets read 0 and `drive_on` reads 0, while strobes still advance the position. After re-enable, the targets show the advanced position.
- R10: `torque` code 00/01/10/11 scales both targets to 100/75/50/20 percent. The result is the magnitude times the percentage divided by 100, truncated, and the sign is applied after scaling.
- R11: A change of `mode` while `home_n` is high has no effect. The resolution is taken only while `home_n` is low.
- R12: A strobe sampled at one rising edge changes the targets at the following rising edge (two-edge latency). The targets do not change at the strobe edge itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| home_n | input | 1 | Active-low park-at-home request |
| step_stb | input | 1 | One-cycle step strobe |
| dir_rev | input | 1 | 0 forward, 1 reverse |
| mode | input | 2 | Step resolution: 00 full, 01 half, 10 quarter, 11 eighth |
| torque | input | 2 | Scale: 00 100%, 01 75%, 10 50%, 11 20% |
| drive_en | input | 1 | 1 drives targets, 0 blanks them |
| cur_a | output | 8 | Signed phase A target in percent |
| cur_b | output | 8 | Signed phase B target in percent |
| drive_on | output | 1 | Registered copy of drive enable |
| at_home | output | 1 | Position equals home of the current resolution |

## Verification
Each resolution is stepped forward through a whole electrical cycle and compared against a position model kept in the bench. This separates a wrong stride, a wrong table entry and a wrong phase offset between A and B. Reverse stepping starts from home and wraps below index zero, which exposes a direction or wrap-around fault. Torque codes are applied at a point where A and B have unlike magnitudes, so a swapped percentage or a rounding error shows up. Blanking, strobes while parked and mode changes while running are each followed by a read of the targets, which shows whether the hidden position moved as required.

// File: rtl/msq_pkg.sv
package msq_pkg;
  localparam int IDX_W  = 5;                  // eighth-steps per cycle = 2**IDX_W
  localparam int QW     = IDX_W - 2;          // bits inside one quarter wave
  localparam int QTR    = 1 << QW;            // eighth-steps per quarter wave
  localparam int OUT_W  = 8;
  localparam int MAG_W  = 7;
  localparam int PCT_W  = 7;
  localparam int PHASES = 2;

  typedef enum logic [1:0] {
    RES_FULL    = 2'b00,
    RES_HALF    = 2'b01,
    RES_QUARTER = 2'b10,
    RES_EIGHTH  = 2'b11
  } res_t;

  function automatic logic [PCT_W-1:0] torque_pct(input logic [1:0] code);
    case (code)
      2'b00:   torque_pct = PCT_W'(100);
      2'b01:   torque_pct = PCT_W'(75);
      2'b10:   torque_pct = PCT_W'(50);
      default: torque_pct = PCT_W'(20);
    endcase
  endfunction

  // Full step parks half a quarter-wave before zero so that A>0 and B<0.
  function automatic logic [IDX_W-1:0] home_index(input res_t r);
    if (r == RES_FULL) home_index = IDX_W'((1 << IDX_W) - QTR / 2);
    else               home_index = '0;
  endfunction
endpackage

// File: rtl/msq_position.sv
module msq_position
  import msq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             home_n,
  input  logic             step_stb,
  input  logic             dir_rev,
  input  logic [1:0]       mode,
  output logic [IDX_W-1:0] pos_q,
  output res_t             res_q
);
  logic [IDX_W-1:0] stride;

  always_comb begin
    stride = IDX_W'(QTR) >> res_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= RES_FULL;
      pos_q <= home_index(RES_FULL);
    end else if (!home_n) begin
      res_q <= res_t'(mode);
      pos_q <= home_index(res_t'(mode));
    end else if (step_stb) begin
      if (dir_rev) pos_q <= pos_q - stride;
      else         pos_q <= pos_q + stride;
    end
  end
endmodule

// File: rtl/msq_phase_lut.sv
module msq_phase_lut
  import msq_pkg::*;
#(
  parameter int OFFSET = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IDX_W-1:0]        pos,
  input  logic                    full_step,
  input  logic [1:0]              torque,
  input  logic                    drive_en,
  output logic signed [OUT_W-1:0] target
);
  localparam int PROD_W = MAG_W + PCT_W;

  logic [IDX_W-1:0]  ph;
  logic [IDX_W-2:0]  half_idx;
  logic [QW:0]       q;
  logic              neg;
  logic [MAG_W-1:0]  rom_mag;
  logic [MAG_W-1:0]  mag;
  logic [PROD_W-1:0] prod;
  logic [MAG_W-1:0]  scaled;
  logic signed [OUT_W-1:0] signed_val;

  always_comb begin
    ph       = pos - IDX_W'(OFFSET);
    half_idx = ph[IDX_W-2:0];
    if (half_idx <= (IDX_W-1)'(QTR)) q = (QW+1)'(half_idx);
    else                             q = (QW+1)'((2 * QTR) - int'(half_idx));
    neg = (ph > IDX_W'(QTR)) && (ph < IDX_W'(3 * QTR));
  end

  // Quarter-wave cosine ROM, percent.
  always_comb begin
    case (q)
      4'd0:    rom_mag = MAG_W'(100);
      4'd1:    rom_mag = MAG_W'(98);
      4'd2:    rom_mag = MAG_W'(92);
      4'd3:    rom_mag = MAG_W'(83);
      4'd4:    rom_mag = MAG_W'(71);
      4'd5:    rom_mag = MAG_W'(56);
      4'd6:    rom_mag = MAG_W'(38);
      4'd7:    rom_mag = MAG_W'(20);
      default: rom_mag = '0;
    endcase
  end

  always_comb begin
    mag        = full_step ? MAG_W'(100) : rom_mag;
    prod       = PROD_W'(mag) * PROD_W'(torque_pct(torque));
    scaled     = MAG_W'(prod / PROD_W'(100));
    signed_val = neg ? -$signed({1'b0, scaled}) : $signed({1'b0, scaled});
  end

  always_ff @(posedge clk) begin
    if (rst)            target <= '0;
    else if (!drive_en) target <= '0;
    else                target <= signed_val;
  end
endmodule

// File: rtl/microstep_seq.sv
module microstep_seq
  import msq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    home_n,
  input  logic                    step_stb,
  input  logic                    dir_rev,
  input  logic [1:0]              mode,
  input  logic [1:0]              torque,
  input  logic                    drive_en,
  output logic signed [OUT_W-1:0] cur_a,
  output logic signed [OUT_W-1:0] cur_b,
  output logic                    drive_on,
  output logic                    at_home
);
  logic [IDX_W-1:0]        pos_q;
  res_t                    res_q;
  logic signed [OUT_W-1:0] tgt [PHASES];

  msq_position u_pos (
    .clk      (clk),
    .rst      (rst),
    .home_n   (home_n),
    .step_stb (step_stb),
    .dir_rev  (dir_rev),
    .mode     (mode),
    .pos_q    (pos_q),
    .res_q    (res_q)
  );

  for (genvar g = 0; g < PHASES; g++) begin : g_phase
    msq_phase_lut #(.OFFSET(g * QTR)) u_lut (
      .clk       (clk),
      .rst       (rst),
      .pos       (pos_q),
      .full_step (res_q == RES_FULL),
      .torque    (torque),
      .drive_en  (drive_en),
      .target    (tgt[g])
    );
  end

  assign cur_a = tgt[0];
  assign cur_b = tgt[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_on <= 1'b0;
      at_home  <= 1'b0;
    end else begin
      drive_on <= drive_en;
      at_home  <= (pos_q == home_index(res_q));
    end
  end
endmodule

// File: rtl/msq_checker.sv
module msq_checker
  import msq_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic                    home_n,
  input logic                    step_stb,
  input logic                    drive_en,
  input logic signed [OUT_W-1:0] cur_a,
  input logic signed [OUT_W-1:0] cur_b,
  input logic                    drive_on,
  input logic                    at_home,
  input logic [IDX_W-1:0]        pos,
  input logic [1:0]              res
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (cur_a == 0 && cur_b == 0 && !drive_on && !at_home));

  a_r2_parked_flag: assert property (@(posedge clk) disable iff (rst)
    (!home_n && $past(!home_n)) |=> at_home);

  a_r8_step_moves: assert property (@(posedge clk) disable iff (rst)
    (home_n && step_stb) |=> !$stable(pos));

  a_r9_blanked: assert property (@(posedge clk) disable iff (rst)
    !drive_en |=> (cur_a == 0 && cur_b == 0 && !drive_on));

  a_r11_mode_locked: assert property (@(posedge clk) disable iff (rst)
    home_n |=> $stable(res));
endmodule

bind microstep_seq msq_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .home_n   (home_n),
  .step_stb (step_stb),
  .drive_en (drive_en),
  .cur_a    (cur_a),
  .cur_b    (cur_b),
  .drive_on (drive_on),
  .at_home  (at_home),
  .pos      (pos_q),
  .res      (res_q)
);

// File: tb/microstep_seq_bench.sv
module microstep_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1, home_n = 1'b0, step_stb = 1'b0, dir_rev = 1'b0, drive_en = 1'b1;
  logic [1:0] mode = 2'b00, torque = 2'b00;
  logic signed [7:0] cur_a, cur_b;
  logic drive_on, at_home;
  int checks = 0, errors = 0;
  int pos = 0, cur_mode = 0;
  bit done = 0;

  always #10 clk = ~clk;

  microstep_seq u_microstep_seq (.*);

  function automatic int qmag(input int q);
    case (q)
      0: return 100; 1: return 98; 2: return 92; 3: return 83; 4: return 71;
      5: return 56;  6: return 38; 7: return 20; default: return 0;
    endcase
  endfunction

  function automatic int expect_val(input int idx, input int m, input int tq);
    int i = ((idx % 32) + 32) % 32;
    int h = i % 16;
    int mg = (m == 0) ? 100 : qmag(h <= 8 ? h : 16 - h);
    int pct = (tq == 0) ? 100 : (tq == 1) ? 75 : (tq == 2) ? 50 : 20;
    int s = mg * pct / 100;
    return (i > 8 && i < 24) ? -s : s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_targets(input string req);
    chk(req, cur_a, expect_val(pos, cur_mode, torque));
    chk(req, cur_b, expect_val(pos - 8, cur_mode, torque));
  endtask

  task automatic park(input int m);
    @(negedge clk); mode = 2'(m); home_n = 1'b0;
    repeat (3) @(negedge clk);
    home_n = 1'b1;
    cur_mode = m;
    pos = (m == 0) ? 28 : 0;
    @(negedge clk);
  endtask

  task automatic step(input bit rev);
    @(negedge clk); dir_rev = rev; step_stb = 1'b1;
    @(negedge clk); step_stb = 1'b0;
    @(negedge clk);
    pos = rev ? pos - (8 >> cur_mode) : pos + (8 >> cur_mode);
    pos = ((pos % 32) + 32) % 32;
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1 cur_a", cur_a, 0); chk("R1 cur_b", cur_b, 0);
    chk("R1 drive_on", drive_on, 0); chk("R1 at_home", at_home, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_home_full();
    park(0);
    chk("R2 full A", cur_a, 100); chk("R2 full B", cur_b, -100);
    chk("R2 flag", at_home, 1);
    @(negedge clk); home_n = 1'b0; step_stb = 1'b1;
    @(negedge clk); step_stb = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 strobe ignored A", cur_a, 100); chk("R2 strobe ignored B", cur_b, -100);
    home_n = 1'b1; @(negedge clk);
  endtask

  task automatic t_full_seq();
    int ea [4] = '{100, -100, -100, 100};
    int eb [4] = '{100, 100, -100, -100};
    park(0);
    @(negedge clk); step_stb = 1'b1; dir_rev = 1'b0;
    @(negedge clk); step_stb = 1'b0;
    chk("R12 no change at strobe edge", cur_a, 100);
    chk("R12 no change at strobe edge B", cur_b, -100);
    @(negedge clk);
    pos = 4;
    chk("R12 updated next edge", cur_b, 100);
    chk("R3 step1 A", cur_a, ea[0]);
    chk("R8 left home", at_home, 0);
    for (int k = 1; k < 4; k++) begin
      step(0);
      chk("R3 A", cur_a, ea[k]); chk("R3 B", cur_b, eb[k]);
    end
    chk("R8 back home", at_home, 1);
  endtask

  task automatic t_res(input int m, input string req);
    park(m);
    chk({req, " home A"}, cur_a, 100); chk({req, " home B (R2)"}, cur_b, 0);
    for (int k = 0; k < (4 << m); k++) begin
      step(0);
      chk_targets(req);
    end
    chk({req, " R8 cycle home"}, at_home, 1);
  endtask

  task automatic t_reverse();
    park(3);
    for (int k = 0; k < 3; k++) begin
      step(1);
      chk_targets("R7 reverse");
    end
    chk("R7 A at -3", cur_a, 83);
    chk("R7 B at -3", cur_b, -56);
  endtask

  task automatic t_enable();
    park(2);
    @(negedge clk); drive_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 blank A", cur_a, 0); chk("R9 blank B", cur_b, 0);
    chk("R9 drive_on", drive_on, 0);
    for (int k = 0; k < 3; k++) step(0);
    chk("R9 still blank", cur_a, 0);
    drive_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 drive_on back", drive_on, 1);
    chk_targets("R9 resumed position");
  endtask

  task automatic t_torque();
    park(3);
    step(0);
    for (int t = 0; t < 4; t++) begin
      @(negedge clk); torque = 2'(t);
      repeat (2) @(negedge clk);
      chk_targets("R10 scale");
    end
    chk("R10 20% of 98", cur_a, 19);
    chk("R10 20% of 20", cur_b, 4);
    for (int k = 0; k < 10; k++) step(0);
    chk_targets("R10 negative truncation");
    @(negedge clk); torque = 2'b00;
  endtask

  task automatic t_mode_locked();
    park(1);
    @(negedge clk); mode = 2'b11;
    step(0);
    chk_targets("R11 mode change ignored");
    chk("R11 half-step A", cur_a, 71);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_home_full();
    t_full_seq();
    t_res(1, "R4");
    t_res(2, "R5");
    t_res(3, "R6");
    t_reverse();
    t_enable();
    t_torque();
    t_mode_locked();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule